// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in the write path of a parallel NOR flash front end. It watches host write cycles. Each cycle is one clock with a strobe asserted, carrying an address and a data word. The block recognises the address-qualified unlock prefixes that guard every destructive flash operation. When a sequence completes, it hands a one-clock request to the embedded operation engine. The request carries an operation code, the address of the final write and the data of the final write.

The unlock addresses depend on the bus width that the host selects. The decoder also keeps a fast-program mode in which a program needs no unlock cycles. While the engine reports busy, most traffic is filtered out. A running erase can be suspended, and a suspended erase can be resumed. The array, the algorithm timing and the supply behaviour belong to other blocks.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, cmd_valid is 0 and fast_mode is 0.
- R2: Unlock keys compare the low 12 address bits and the low data byte. With byte_mode=0 the first key is 555h and the second is 2AAh. With byte_mode=1 the first key is AAAh and the second is 555h. A program is AAh at the first key, then 55h at the second key, then A0h at the first key, then any write. It yields cmd_op=1 with the address and data of that last write.
- R3: Chip erase is the unlock pair, 80h at the first key, the unlock pair again, then 10h at the first key. It yields cmd_op=2.
- R4: The sector erase prefix is the same five cycles as chip erase. After it, a 30h write to any address yields cmd_op=3 with that address. Every further 30h write adds one more sector (cmd_op=3). Any other write closes the list without a request.
- R5: The unlock pair followed by 90h at the first key yields cmd_op=4 (autoselect).
- R6: Outside fast mode, an F0h write yields cmd_op=5 and returns the decoder to idle. This applies on its own or after an unlock prefix, but not as the data cycle of a program.
- R7: A write that does not match the expected next cycle of a sequence ends that sequence without a request. The next sequence must start again from its first cycle.
- R8: The unlock pair followed by 20h at the first key yields cmd_op=8 and sets fast_mode. In fast mode, A0h to any address followed by any write yields cmd_op=1. Other writes issue nothing and leave fast_mode set.
- R9: In fast mode, 90h followed by F0h (any addresses) yields cmd_op=9 and clears fast_mode. A 90h followed by anything else leaves fast mode set and issues nothing.
- R10: While eng_busy=1, writes issue nothing except three cases. F0h gives reset. B0h gives cmd_op=6, but only when eng_erasing=1. 30h while a sector list is open adds a sector.
- R11: In idle with eng_busy=0 and eng_suspended=1, a 30h write yields cmd_op=7 (resume) with its address.
- R12: cmd_valid is high for exactly one clock, the clock after the write's strobe edge. There is never a request without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Marks one bus write in this clock |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command codes in the low byte |
| byte_mode | input | 1 | 1 selects byte-wide unlock keys |
| eng_busy | input | 1 | Engine running an operation |
| eng_erasing | input | 1 | Engine running an erase |
| eng_suspended | input | 1 | Engine holds a suspended erase |
| cmd_valid | output | 1 | One-clock request strobe |
| cmd_op | output | 4 | Operation code of the request |
| cmd_addr | output | AW | Address of the final write |
| cmd_data | output | DW | Data of the final write |
| fast_mode | output | 1 | Fast-program mode active |

## Verification
Each request comes from a single register stage. It therefore appears in the clock that follows the edge on which the final strobe was sampled, and fast_mode changes on that same edge. The driver applies every write at a falling edge and queues the request it expects. The monitor samples at the next falling edge, half a period after the result is due. This way an early, late or missing request shows up as a mismatch or as a leftover item in the queue. Ignored writes are proven harmless in two ways: no request appears for them, and a following sequence behaves as it would from the idle state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int KW    = 12;
    localparam int NCODE = 10;

    localparam int C_AA = 0;
    localparam int C_55 = 1;
    localparam int C_A0 = 2;
    localparam int C_80 = 3;
    localparam int C_10 = 4;
    localparam int C_30 = 5;
    localparam int C_20 = 6;
    localparam int C_90 = 7;
    localparam int C_F0 = 8;
    localparam int C_B0 = 9;

    localparam logic [7:0] CODE_TAB [NCODE] = '{
        8'hAA, 8'h55, 8'hA0, 8'h80, 8'h10,
        8'h30, 8'h20, 8'h90, 8'hF0, 8'hB0
    };

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_PROGRAM    = 4'd1,
        OP_CHIP_ERASE = 4'd2,
        OP_SECT_ERASE = 4'd3,
        OP_AUTOSEL    = 4'd4,
        OP_RESET      = 4'd5,
        OP_SUSPEND    = 4'd6,
        OP_RESUME     = 4'd7,
        OP_FAST_ENTER = 4'd8,
        OP_FAST_EXIT  = 4'd9
    } cmd_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_SECT,
        ST_FAST,
        ST_FPROG,
        ST_FEXIT
    } seq_state_e;

endpackage

// File: rtl/fcmd_addr_match.sv
module fcmd_addr_match
    import fcmd_pkg::*;
(
    input  logic [KW-1:0] addr_lo,
    input  logic          byte_mode,
    output logic          key1_hit,
    output logic          key2_hit
);
    localparam logic [KW-1:0] W_KEY1 = KW'(12'h555);
    localparam logic [KW-1:0] W_KEY2 = KW'(12'h2AA);
    localparam logic [KW-1:0] B_KEY1 = KW'(12'hAAA);
    localparam logic [KW-1:0] B_KEY2 = KW'(12'h555);

    logic [KW-1:0] key1;
    logic [KW-1:0] key2;

    always_comb begin
        key1     = byte_mode ? B_KEY1 : W_KEY1;
        key2     = byte_mode ? B_KEY2 : W_KEY2;
        key1_hit = (addr_lo == key1);
        key2_hit = (addr_lo == key2);
    end
endmodule

// File: rtl/fcmd_code_decode.sv
module fcmd_code_decode
    import fcmd_pkg::*;
(
    input  logic [7:0]       data_lo,
    output logic [NCODE-1:0] code_hit
);
    for (genvar i = 0; i < NCODE; i++) begin : g_code
        assign code_hit[i] = (data_lo == CODE_TAB[i]);
    end
endmodule

// File: rtl/fcmd_seq_fsm.sv
module fcmd_seq_fsm
    import fcmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             key1_hit,
    input  logic             key2_hit,
    input  logic [NCODE-1:0] code_hit,
    input  logic             eng_busy,
    input  logic             eng_erasing,
    input  logic             eng_suspended,
    output logic             cmd_valid,
    output cmd_op_e          cmd_op,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_data,
    output logic             fast_mode
);
    typedef struct packed {
        seq_state_e    st;
        logic          vld;
        cmd_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } regs_t;

    regs_t   d, q;
    logic    fire;
    cmd_op_e fop;
    logic    in_fast;

    assign in_fast = (q.st == ST_FAST) || (q.st == ST_FPROG) || (q.st == ST_FEXIT);

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.op  = OP_NONE;
        fire  = 1'b0;
        fop   = OP_NONE;
        if (wr_stb) begin
            if (in_fast) begin
                // fast mode: only the two-cycle program and the exit pair
                if (!eng_busy) begin
                    case (q.st)
                        ST_FAST: begin
                            if (code_hit[C_A0])      d.st = ST_FPROG;
                            else if (code_hit[C_90]) d.st = ST_FEXIT;
                        end
                        ST_FPROG: begin
                            fire = 1'b1;
                            fop  = OP_PROGRAM;
                            d.st = ST_FAST;
                        end
                        ST_FEXIT: begin
                            if (code_hit[C_F0]) begin
                                fire = 1'b1;
                                fop  = OP_FAST_EXIT;
                                d.st = ST_IDLE;
                            end else begin
                                d.st = ST_FAST;
                            end
                        end
                        default: d.st = ST_FAST;
                    endcase
                end
            end else if (q.st == ST_PROG) begin
                // the data cycle of a program takes any value
                if (!eng_busy) begin
                    fire = 1'b1;
                    fop  = OP_PROGRAM;
                    d.st = ST_IDLE;
                end
            end else if (code_hit[C_F0]) begin
                fire = 1'b1;
                fop  = OP_RESET;
                d.st = ST_IDLE;
            end else if (code_hit[C_B0] && eng_erasing) begin
                fire = 1'b1;
                fop  = OP_SUSPEND;
                d.st = ST_IDLE;
            end else if (q.st == ST_SECT) begin
                // open sector list: accepted even while the engine is busy
                if (code_hit[C_30]) begin
                    fire = 1'b1;
                    fop  = OP_SECT_ERASE;
                end else begin
                    d.st = ST_IDLE;
                end
            end else if (!eng_busy) begin
                case (q.st)
                    ST_IDLE: begin
                        if (code_hit[C_AA] && key1_hit) begin
                            d.st = ST_UNL1;
                        end else if (code_hit[C_30] && eng_suspended) begin
                            fire = 1'b1;
                            fop  = OP_RESUME;
                        end
                    end
                    ST_UNL1: d.st = (code_hit[C_55] && key2_hit) ? ST_UNL2 : ST_IDLE;
                    ST_UNL2: begin
                        d.st = ST_IDLE;
                        if (key1_hit) begin
                            if (code_hit[C_A0]) begin
                                d.st = ST_PROG;
                            end else if (code_hit[C_80]) begin
                                d.st = ST_ERS1;
                            end else if (code_hit[C_20]) begin
                                fire = 1'b1;
                                fop  = OP_FAST_ENTER;
                                d.st = ST_FAST;
                            end else if (code_hit[C_90]) begin
                                fire = 1'b1;
                                fop  = OP_AUTOSEL;
                            end
                        end
                    end
                    ST_ERS1: d.st = (code_hit[C_AA] && key1_hit) ? ST_ERS2 : ST_IDLE;
                    ST_ERS2: d.st = (code_hit[C_55] && key2_hit) ? ST_ERS3 : ST_IDLE;
                    ST_ERS3: begin
                        d.st = ST_IDLE;
                        if (code_hit[C_10] && key1_hit) begin
                            fire = 1'b1;
                            fop  = OP_CHIP_ERASE;
                        end else if (code_hit[C_30]) begin
                            fire = 1'b1;
                            fop  = OP_SECT_ERASE;
                            d.st = ST_SECT;
                        end
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
        if (fire) begin
            d.vld  = 1'b1;
            d.op   = fop;
            d.addr = wr_addr;
            d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.vld  <= 1'b0;
            q.op   <= OP_NONE;
            q.addr <= '0;
            q.data <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid = q.vld;
    assign cmd_op    = q.op;
    assign cmd_addr  = q.addr;
    assign cmd_data  = q.data;
    assign fast_mode = in_fast;
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          byte_mode,
    input  logic          eng_busy,
    input  logic          eng_erasing,
    input  logic          eng_suspended,
    output logic          cmd_valid,
    output logic [3:0]    cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic          fast_mode
);
    logic             key1_hit;
    logic             key2_hit;
    logic [NCODE-1:0] code_hit;
    cmd_op_e          op_w;

    fcmd_addr_match u_amatch (
        .addr_lo   (wr_addr[KW-1:0]),
        .byte_mode (byte_mode),
        .key1_hit  (key1_hit),
        .key2_hit  (key2_hit)
    );

    fcmd_code_decode u_cdec (
        .data_lo  (wr_data[7:0]),
        .code_hit (code_hit)
    );

    fcmd_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_stb        (wr_stb),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .key1_hit      (key1_hit),
        .key2_hit      (key2_hit),
        .code_hit      (code_hit),
        .eng_busy      (eng_busy),
        .eng_erasing   (eng_erasing),
        .eng_suspended (eng_suspended),
        .cmd_valid     (cmd_valid),
        .cmd_op        (op_w),
        .cmd_addr      (cmd_addr),
        .cmd_data      (cmd_data),
        .fast_mode     (fast_mode)
    );

    assign cmd_op = op_w;
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       eng_busy,
    input logic       eng_erasing,
    input logic       eng_suspended,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       fast_mode
);
    // R12: a request always follows a write strobe by one clock
    p_req_needs_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_stb));

    // R12: a request carries a real operation code
    p_req_has_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != 4'd0));

    // R8: entering fast mode comes with the enter request
    p_fast_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_mode) |-> (cmd_valid && cmd_op == 4'd8));

    // R9: leaving fast mode comes with the exit request
    p_fast_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_mode) |-> (cmd_valid && cmd_op == 4'd9));

    // R10: while busy only reset, suspend or sector add get through
    p_busy_filter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(eng_busy)) |->
        (cmd_op == 4'd5 || cmd_op == 4'd6 || cmd_op == 4'd3));

    // R10: suspend only while an erase runs
    p_suspend_erasing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd6) |-> $past(eng_erasing));

    // R11: resume only for a suspended, idle engine
    p_resume_cond_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd7) |-> ($past(eng_suspended) && !$past(eng_busy)));

    // R6: reset never leaves fast mode set
    p_reset_not_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd5) |-> !fast_mode);
endmodule

bind fcmd_decoder fcmd_decoder_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .eng_busy      (eng_busy),
    .eng_erasing   (eng_erasing),
    .eng_suspended (eng_suspended),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .fast_mode     (fast_mode)
);

// File: tb/fcmd_decoder_tb_top.sv
`timescale 1ns/1ps
module fcmd_decoder_tb_top;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          byte_mode = 1'b0;
    logic          eng_busy = 1'b0;
    logic          eng_erasing = 1'b0;
    logic          eng_suspended = 1'b0;
    logic          cmd_valid;
    logic [3:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          fast_mode;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic [3:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    fcmd_decoder #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .byte_mode(byte_mode), .eng_busy(eng_busy),
        .eng_erasing(eng_erasing), .eng_suspended(eng_suspended),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .fast_mode(fast_mode)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    // monitor: compare each request against the scoreboard
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            checks = checks + 1;
            if (sbq.size() == 0) begin
                fails = fails + 1;
                $display("FAIL R12 unexpected request: actual op=%0d addr=%h expected none",
                         cmd_op, cmd_addr);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (cmd_op !== e.op || cmd_addr !== e.addr || cmd_data !== e.data) begin
                    fails = fails + 1;
                    $display("FAIL %s: actual op=%0d addr=%h data=%h expected op=%0d addr=%h data=%h",
                             e.tag, cmd_op, cmd_addr, cmd_data, e.op, e.addr, e.data);
                end
            end
        end
    end

    task automatic expect_req(input logic [3:0] op, input logic [AW-1:0] a,
                              input logic [DW-1:0] dt, input string tag);
        exp_t e;
        e.op = op; e.addr = a; e.data = dt; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] dt);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = dt;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic drained(input string tag);
        @(negedge clk);
        checks = checks + 1;
        if (sbq.size() != 0) begin
            fails = fails + 1;
            $display("FAIL %s: actual pending=%0d expected pending=0", tag, sbq.size());
            sbq.delete();
        end
    endtask

    function automatic logic [AW-1:0] k1();
        return byte_mode ? 20'h00AAA : 20'h00555;
    endfunction
    function automatic logic [AW-1:0] k2();
        return byte_mode ? 20'h00555 : 20'h002AA;
    endfunction

    task automatic unlock();
        wr(k1(), 16'h00AA);
        wr(k2(), 16'h0055);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_bit(cmd_valid, 1'b0, "R1 valid at reset");
        check_bit(fast_mode, 1'b0, "R1 fast at reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 word-mode program
        unlock(); wr(k1(), 16'h00A0);
        expect_req(4'd1, 20'h12345, 16'hC35A, "R2 word program");
        wr(20'h12345, 16'hC35A);
        drained("R2 word program");
        check_bit(cmd_valid, 1'b0, "R12 single-cycle pulse");

        // R2 byte-mode program
        byte_mode = 1'b1;
        unlock(); wr(k1(), 16'h00A0);
        expect_req(4'd1, 20'h0F00F, 16'h00F0, "R2 byte program");
        wr(20'h0F00F, 16'h00F0);
        drained("R2 byte program");

        // R7 word keys in byte mode: no match, then a clean program works
        wr(20'h00555, 16'h00AA); wr(20'h002AA, 16'h0055); wr(20'h00555, 16'h00A0);
        wr(20'h00777, 16'h0011);
        drained("R7 wrong-width keys");
        byte_mode = 1'b0;

        // R3 chip erase
        unlock(); wr(k1(), 16'h0080); unlock();
        expect_req(4'd2, 20'h00555, 16'h0010, "R3 chip erase");
        wr(k1(), 16'h0010);
        drained("R3 chip erase");

        // R4 sector erase with one added sector, then list closed
        unlock(); wr(k1(), 16'h0080); unlock();
        expect_req(4'd3, 20'h10000, 16'h0030, "R4 first sector");
        wr(20'h10000, 16'h0030);
        expect_req(4'd3, 20'h20000, 16'h0030, "R4 added sector");
        wr(20'h20000, 16'h0030);
        wr(20'h00000, 16'h0000);
        wr(20'h30000, 16'h0030);
        drained("R4 list closed");

        // R5 autoselect
        unlock();
        expect_req(4'd4, 20'h00555, 16'h0090, "R5 autoselect");
        wr(k1(), 16'h0090);
        drained("R5 autoselect");

        // R6 both reset forms
        expect_req(4'd5, 20'h54321, 16'h00F0, "R6 plain reset");
        wr(20'h54321, 16'h00F0);
        unlock();
        expect_req(4'd5, 20'h00555, 16'h00F0, "R6 unlocked reset");
        wr(k1(), 16'h00F0);
        drained("R6 reset");

        // R7 mismatch aborts; A0 afterwards must not arm a program
        unlock(); wr(k1(), 16'h0077);
        wr(k1(), 16'h00A0); wr(20'h00100, 16'h0022);
        drained("R7 abort");
        check_bit(fast_mode, 1'b0, "R7 mode after abort");

        // R8 fast mode
        unlock();
        expect_req(4'd8, 20'h00555, 16'h0020, "R8 fast enter");
        wr(k1(), 16'h0020);
        drained("R8 fast enter");
        check_bit(fast_mode, 1'b1, "R8 fast set");
        wr(20'hABCDE, 16'h00A0);
        expect_req(4'd1, 20'h00100, 16'h0033, "R8 fast program");
        wr(20'h00100, 16'h0033);
        wr(20'h00000, 16'h0044);
        wr(20'h00000, 16'h00F0);
        drained("R8 stray writes in fast mode");
        check_bit(fast_mode, 1'b1, "R8 fast kept");

        // R9 exit pair
        wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0011);
        drained("R9 broken exit");
        check_bit(fast_mode, 1'b1, "R9 fast kept after broken exit");
        wr(20'h00003, 16'h0090);
        expect_req(4'd9, 20'h00007, 16'h00F0, "R9 fast exit");
        wr(20'h00007, 16'h00F0);
        drained("R9 fast exit");
        check_bit(fast_mode, 1'b0, "R9 fast cleared");

        // R10 busy filter
        eng_busy = 1'b1;
        unlock(); wr(k1(), 16'h00A0); wr(20'h00200, 16'h0055);
        wr(20'h50000, 16'h00B0);
        drained("R10 busy, not erasing");
        eng_erasing = 1'b1;
        expect_req(4'd6, 20'h50000, 16'h00B0, "R10 suspend");
        wr(20'h50000, 16'h00B0);
        expect_req(4'd5, 20'h00000, 16'h00F0, "R10 reset while busy");
        wr(20'h00000, 16'h00F0);
        drained("R10 busy");

        // R11 resume
        eng_busy = 1'b0; eng_erasing = 1'b0; eng_suspended = 1'b1;
        expect_req(4'd7, 20'h40000, 16'h0030, "R11 resume");
        wr(20'h40000, 16'h0030);
        drained("R11 resume");
        eng_suspended = 1'b0;
        wr(20'h40000, 16'h0030);
        drained("R11 no resume when not suspended");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule